// File: doc/BRIEF.md
# Transport Stream Packet-Identifier Filter

This block sits in the byte-wide path of a transport stream input and decides, for every 188-byte packet, whether it travels on or is thrown away. It holds back the first eight bytes of each packet and joins them into a 64-bit word, first byte in the most significant position. It cuts a packet identifier out of that word at a bit position and bit count set by software. It then reads one bit for that identifier from a local bitmap that covers all 8192 identifiers. A set bit forwards the whole packet. A clear bit drops the whole packet. A packet is never cut short.

Software fills the bitmap through a simple word-write port: 256 words of 32 bits. It can wipe the whole map with a single pulse, and it can turn filtering off with a global enable so that every packet passes. Both stream sides use valid/ready handshakes. The input carries a start-of-packet marker. The output marks the first and last byte of every forwarded packet. Two counters report how many packets were passed and how many were dropped.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, both packet counters read 0, and every bitmap bit is clear.
- R2: Bytes 0..7 of a packet form a word in which byte 0 occupies bits 63:56 and byte 7 occupies bits 7:0. The identifier is the slice from bit cfg_pid_lsb + cfg_pid_width - 1 down to bit cfg_pid_lsb. Bit positions above 63 read as zero. A width above 13 acts as 13. Offset 40 with width 13 gives the usual 13-bit identifier.
- R3: Bitmap word w, bit j stands for identifier 32*w + j. When filtering is on and that bit is set, all 188 bytes of the packet leave unchanged and in order. out_sop is high on byte 0 only, and out_eop is high on byte 187 only.
- R4: When filtering is on and the identifier's bit is clear, all 188 bytes are consumed and nothing appears on the output.
- R5: With cfg_filter_en at 0, every packet is forwarded, whatever the bitmap holds.
- R6: A one-cycle pulse on tbl_clear clears every bitmap bit. After it, packets that passed before are dropped.
- R7: While the block waits for a packet start, bytes without in_sop are accepted and discarded.
- R8: A bitmap write made after a packet's header has been examined does not change that packet's fate. The write applies from the next packet on.
- R9: pass_count and drop_count each rise by exactly one for every packet that is forwarded or dropped, respectively.
- R10: When out_ready is held low, the block stalls without losing, repeating or reordering a byte. in_ready is 0 while stored header bytes are being sent out.
- R11: With offset 0 and a width below 8, only the low bits of byte 7 form the identifier. With offset 60 and width 8, the upper nibble of byte 0 forms the identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte is first of a packet |
| in_ready | output | 1 | Block accepts the input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | Output byte is first of a packet |
| out_eop | output | 1 | Output byte is last of a packet |
| out_ready | input | 1 | Downstream accepts the output byte |
| cfg_filter_en | input | 1 | 1: filter by bitmap, 0: pass all |
| cfg_pid_lsb | input | 6 | Lowest bit of identifier slice in the header word |
| cfg_pid_width | input | 4 | Number of identifier bits (saturates at 13) |
| tbl_we | input | 1 | Bitmap word write strobe |
| tbl_addr | input | 8 | Bitmap word index |
| tbl_wdata | input | 32 | Bitmap word value |
| tbl_clear | input | 1 | Clear whole bitmap |
| pass_count | output | 16 | Packets forwarded |
| drop_count | output | 16 | Packets dropped |

## Verification
The bench aims at the identifier slice edges. It uses flag bits sharing a byte with the identifier, offsets whose window runs past bit 63, and identifier 8191 at the last word's top bit. A design that masked wrongly, wrapped the index or swapped byte order would pass the wrong packets. It also writes the bitmap in the middle of a packet body, where a design that looked the bit up late would flip the fate of a packet already in flight. It runs a packet under repeated output stalls, where a design that ignored backpressure during header replay would drop or duplicate bytes. It also feeds stray bytes before a start marker, which a careless design would frame as a packet.

// File: rtl/ts_pidf_pkg.sv
package ts_pidf_pkg;

    localparam int unsigned DEF_PKT_LEN = 188;
    localparam int unsigned DEF_PID_W   = 13;
    localparam int unsigned DEF_WORD_W  = 32;
    localparam int unsigned DEF_CNT_W   = 16;
    localparam int unsigned HDR_BYTES   = 8;
    localparam int unsigned HDR_BITS    = HDR_BYTES * 8;

    typedef enum logic [2:0] {
        ST_HUNT   = 3'd0,
        ST_HDR    = 3'd1,
        ST_LOOK   = 3'd2,
        ST_DEC    = 3'd3,
        ST_REPLAY = 3'd4,
        ST_BODY   = 3'd5
    } pidf_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic       sop;
        logic       eop;
    } pidf_beat_t;

    function automatic int unsigned clog2_min1(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/ts_pidf_slicer.sv
module ts_pidf_slicer
    import ts_pidf_pkg::*;
#(
    parameter int unsigned PID_W = DEF_PID_W,
    parameter int unsigned LSB_W = $clog2(HDR_BITS),
    parameter int unsigned WID_W = $clog2(PID_W + 1)
) (
    input  logic [HDR_BITS-1:0] hdr_word,
    input  logic [LSB_W-1:0]    lsb,
    input  logic [WID_W-1:0]    width,
    output logic [PID_W-1:0]    pid
);
    localparam int unsigned IDX_W = $clog2(2 * HDR_BITS);

    logic [2*HDR_BITS-1:0] ext;
    logic [WID_W-1:0]      wid_eff;

    assign ext     = {{HDR_BITS{1'b0}}, hdr_word};
    assign wid_eff = (width > WID_W'(PID_W)) ? WID_W'(PID_W) : width;

    for (genvar k = 0; k < PID_W; k++) begin : g_bit
        logic [IDX_W-1:0] idx;
        assign idx    = IDX_W'(lsb) + IDX_W'(k);
        assign pid[k] = (WID_W'(k) < wid_eff) ? ext[idx] : 1'b0;
    end

endmodule

// File: rtl/ts_pidf_bitmap.sv
module ts_pidf_bitmap
    import ts_pidf_pkg::*;
#(
    parameter int unsigned PID_W  = DEF_PID_W,
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned BIT_W  = $clog2(WORD_W),
    parameter int unsigned ADDR_W = PID_W - BIT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clr,
    input  logic              rd_en,
    input  logic [PID_W-1:0]  rd_pid,
    output logic              rd_bit
);
    localparam int unsigned WORDS = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                mem[w] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(w))) begin
                mem[w] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bit <= 1'b0;
        end else if (rd_en) begin
            rd_bit <= mem[rd_pid[PID_W-1:BIT_W]][rd_pid[BIT_W-1:0]];
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr) |=> (mem[$past(wr_addr)] == $past(wr_data))); // R3

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((mem[0] == '0) && (mem[WORDS-1] == '0))); // R6

endmodule

// File: rtl/ts_pidf_counters.sv
module ts_pidf_counters
    import ts_pidf_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             passed,
    output logic [CNT_W-1:0] pass_cnt,
    output logic [CNT_W-1:0] drop_cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pass_cnt <= '0;
            drop_cnt <= '0;
        end else if (fire) begin
            if (passed) pass_cnt <= pass_cnt + 1'b1;
            else        drop_cnt <= drop_cnt + 1'b1;
        end
    end

    AST_ONE_COUNTER_MOVES: assert property (@(posedge clk) disable iff (rst)
        fire |=> ($countones({pass_cnt != $past(pass_cnt),
                              drop_cnt != $past(drop_cnt)}) == 1)); // R9

    AST_COUNTERS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !fire |=> ($stable(pass_cnt) && $stable(drop_cnt))); // R9

endmodule

// File: rtl/ts_pidf_engine.sv
module ts_pidf_engine
    import ts_pidf_pkg::*;
#(
    parameter int unsigned PKT_LEN = DEF_PKT_LEN,
    parameter int unsigned BCNT_W  = $clog2(PKT_LEN)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [7:0]          in_data,
    input  logic                in_sop,
    output logic                in_ready,
    output pidf_beat_t          out_beat,
    input  logic                out_ready,
    input  logic                cfg_en,
    input  logic                lk_bit,
    output logic                lk_req,
    output logic [HDR_BITS-1:0] hdr_word,
    output logic                dec_fire,
    output logic                dec_pass
);
    localparam int unsigned REP_W = $clog2(HDR_BYTES);

    pidf_state_e       state;
    logic [BCNT_W-1:0] byte_cnt;
    logic [REP_W-1:0]  rep_idx;
    logic              pass_q;
    logic              en_q;
    logic              in_fire;

    assign lk_req   = (state == ST_LOOK);
    assign dec_fire = (state == ST_DEC);
    assign dec_pass = !en_q || lk_bit;
    assign in_fire  = in_valid && in_ready;

    always_comb begin
        in_ready = 1'b0;
        out_beat = '0;
        unique case (state)
            ST_HUNT, ST_HDR: in_ready = 1'b1;
            ST_REPLAY: begin
                out_beat.valid = 1'b1;
                out_beat.data  = hdr_word[HDR_BITS-1-8*int'(rep_idx) -: 8];
                out_beat.sop   = (rep_idx == '0);
            end
            ST_BODY: begin
                in_ready       = pass_q ? out_ready : 1'b1;
                out_beat.valid = pass_q && in_valid;
                out_beat.data  = in_data;
                out_beat.eop   = (byte_cnt == BCNT_W'(PKT_LEN - 1));
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            hdr_word <= '0;
            byte_cnt <= '0;
            rep_idx  <= '0;
            pass_q   <= 1'b0;
            en_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    if (in_valid && in_sop) begin
                        hdr_word <= {hdr_word[HDR_BITS-9:0], in_data};
                        byte_cnt <= BCNT_W'(1);
                        state    <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (in_valid) begin
                        hdr_word <= {hdr_word[HDR_BITS-9:0], in_data};
                        byte_cnt <= byte_cnt + 1'b1;
                        if (byte_cnt == BCNT_W'(HDR_BYTES - 1)) state <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    en_q  <= cfg_en;
                    state <= ST_DEC;
                end
                ST_DEC: begin
                    pass_q  <= dec_pass;
                    rep_idx <= '0;
                    state   <= dec_pass ? ST_REPLAY : ST_BODY;
                end
                ST_REPLAY: begin
                    if (out_ready) begin
                        rep_idx <= rep_idx + 1'b1;
                        if (rep_idx == REP_W'(HDR_BYTES - 1)) state <= ST_BODY;
                    end
                end
                ST_BODY: begin
                    if (in_fire) begin
                        byte_cnt <= byte_cnt + 1'b1;
                        if (byte_cnt == BCNT_W'(PKT_LEN - 1)) state <= ST_HUNT;
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    AST_EOP_ENDS_PACKET: assert property (@(posedge clk) disable iff (rst)
        (out_beat.valid && out_ready && out_beat.eop) |=> (state == ST_HUNT)); // R3

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (dec_fire && !dec_pass) |=> !out_beat.valid); // R4

    AST_DISABLED_PASSES: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !cfg_en) |=> dec_pass); // R5

    AST_REPLAY_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REPLAY && !out_ready) |=> $stable(out_beat.data)); // R10

    AST_NO_INTAKE_IN_REPLAY: assert property (@(posedge clk) disable iff (rst)
        (dec_fire && dec_pass) |=> !in_ready); // R10

endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
    import ts_pidf_pkg::*;
#(
    parameter int unsigned PKT_LEN = DEF_PKT_LEN,
    parameter int unsigned PID_W   = DEF_PID_W,
    parameter int unsigned WORD_W  = DEF_WORD_W,
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter int unsigned LSB_W   = $clog2(HDR_BITS),
    parameter int unsigned WID_W   = $clog2(PID_W + 1),
    parameter int unsigned ADDR_W  = PID_W - $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_sop,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_sop,
    output logic              out_eop,
    input  logic              out_ready,
    input  logic              cfg_filter_en,
    input  logic [LSB_W-1:0]  cfg_pid_lsb,
    input  logic [WID_W-1:0]  cfg_pid_width,
    input  logic              tbl_we,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [WORD_W-1:0] tbl_wdata,
    input  logic              tbl_clear,
    output logic [CNT_W-1:0]  pass_count,
    output logic [CNT_W-1:0]  drop_count
);
    pidf_beat_t          beat;
    logic [HDR_BITS-1:0] hdr_word;
    logic [PID_W-1:0]    pid;
    logic                lk_req;
    logic                lk_bit;
    logic                dec_fire;
    logic                dec_pass;

    ts_pidf_engine #(.PKT_LEN(PKT_LEN)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_sop   (in_sop),
        .in_ready (in_ready),
        .out_beat (beat),
        .out_ready(out_ready),
        .cfg_en   (cfg_filter_en),
        .lk_bit   (lk_bit),
        .lk_req   (lk_req),
        .hdr_word (hdr_word),
        .dec_fire (dec_fire),
        .dec_pass (dec_pass)
    );

    ts_pidf_slicer #(.PID_W(PID_W), .LSB_W(LSB_W), .WID_W(WID_W)) u_slicer (
        .hdr_word(hdr_word),
        .lsb     (cfg_pid_lsb),
        .width   (cfg_pid_width),
        .pid     (pid)
    );

    ts_pidf_bitmap #(.PID_W(PID_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_bitmap (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (tbl_we),
        .wr_addr(tbl_addr),
        .wr_data(tbl_wdata),
        .clr    (tbl_clear),
        .rd_en  (lk_req),
        .rd_pid (pid),
        .rd_bit (lk_bit)
    );

    ts_pidf_counters #(.CNT_W(CNT_W)) u_counters (
        .clk     (clk),
        .rst     (rst),
        .fire    (dec_fire),
        .passed  (dec_pass),
        .pass_cnt(pass_count),
        .drop_cnt(drop_count)
    );

    assign out_valid = beat.valid;
    assign out_data  = beat.data;
    assign out_sop   = beat.sop;
    assign out_eop   = beat.eop;

    AST_NO_OUTPUT_AFTER_RESET: assert property (@(posedge clk)
        rst |=> !out_valid); // R1

endmodule

// File: tb/ts_pid_filter_tb.sv
module ts_pid_filter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_sop;
    logic        out_eop;
    logic        out_ready = 1'b1;
    logic        cfg_filter_en = 1'b1;
    logic [5:0]  cfg_pid_lsb = 6'd40;
    logic [3:0]  cfg_pid_width = 4'd13;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_addr = '0;
    logic [31:0] tbl_wdata = '0;
    logic        tbl_clear = 1'b0;
    logic [15:0] pass_count;
    logic [15:0] drop_count;

    int tests = 0;
    int fails = 0;
    int exp_pass = 0;
    int exp_drop = 0;
    int cyc = 0;
    bit bp_mode = 1'b0;

    logic [7:0] cap_d [200];
    logic       cap_s [200];
    logic       cap_e [200];
    int         cap_n = 0;

    always #5 clk = ~clk;

    ts_pid_filter u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .out_ready(out_ready),
        .cfg_filter_en(cfg_filter_en), .cfg_pid_lsb(cfg_pid_lsb), .cfg_pid_width(cfg_pid_width),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .tbl_clear(tbl_clear),
        .pass_count(pass_count), .drop_count(drop_count)
    );

    // {en, lsb, width, header, expect_pass}
    localparam logic [75:0] VEC [10] = '{
        {1'b1, 6'd40, 4'd13, 64'h4701_0010_0000_0000, 1'b1},
        {1'b1, 6'd40, 4'd13, 64'h4701_0110_0000_0000, 1'b0},
        {1'b1, 6'd40, 4'd13, 64'h47FF_FF10_0000_0000, 1'b1},
        {1'b1, 6'd40, 4'd13, 64'h475F_FE10_0000_0000, 1'b0},
        {1'b0, 6'd40, 4'd13, 64'h4701_0110_0000_0000, 1'b1},
        {1'b1, 6'd0,  4'd8,  64'h4712_3410_0000_0002, 1'b1},
        {1'b1, 6'd0,  4'd8,  64'h4712_3410_0000_0003, 1'b0},
        {1'b1, 6'd0,  4'd4,  64'h4712_3410_0000_0032, 1'b1},
        {1'b1, 6'd60, 4'd8,  64'h2700_0000_0000_000F, 1'b1},
        {1'b1, 6'd35, 4'd6,  64'h4700_0118_0000_0000, 1'b1}
    };
    localparam string VTAG [10] = '{"R3", "R4", "R2", "R4", "R5",
                                    "R11", "R11", "R11", "R2", "R2"};

    always @(negedge clk) begin
        cyc = cyc + 1;
        out_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
        #2;
        if (out_valid && out_ready && cap_n < 200) begin
            cap_d[cap_n] = out_data;
            cap_s[cap_n] = out_sop;
            cap_e[cap_n] = out_eop;
            cap_n = cap_n + 1;
        end
    end

    function automatic logic [7:0] pkt_byte(input logic [63:0] hdr, input int i, input int seed);
        if (i < 8) return hdr[63-8*i -: 8];
        return 8'((i * 7 + seed) & 255);
    endfunction

    task automatic chk(input string tag, input logic ok, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tbl_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic send_pkt(input logic [63:0] hdr, input int seed, input bit mid_wr,
                            input logic [7:0] wa, input logic [31:0] wd);
        for (int i = 0; i < 188; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pkt_byte(hdr, i, seed);
            in_sop   = (i == 0);
            tbl_we   = mid_wr && (i == 60);
            tbl_addr = wa;
            tbl_wdata = wd;
            #2;
            while (!in_ready) begin
                @(negedge clk);
                tbl_we = 1'b0;
                #2;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; tbl_we = 1'b0;
    endtask

    task automatic run_pkt(input string tag, input logic [63:0] hdr, input int seed,
                           input bit exp_fwd, input bit mid_wr,
                           input logic [7:0] wa, input logic [31:0] wd);
        int bad;
        cap_n = 0;
        send_pkt(hdr, seed, mid_wr, wa, wd);
        repeat (6) @(negedge clk);
        #3;
        bad = 0;
        if (exp_fwd) begin
            exp_pass++;
            for (int i = 0; i < 188 && i < cap_n; i++) begin
                if (cap_d[i] != pkt_byte(hdr, i, seed) || cap_s[i] != (i == 0) ||
                    cap_e[i] != (i == 187)) bad++;
            end
            chk(tag, (cap_n == 188) && (bad == 0), cap_n + bad * 1000, 188);
        end else begin
            exp_drop++;
            chk(tag, cap_n == 0, cap_n, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        chk("R1 out_valid", out_valid == 1'b0, out_valid, 0);
        chk("R1 in_ready", in_ready == 1'b1, in_ready, 1);
        chk("R1 counters", pass_count == 0 && drop_count == 0, {pass_count, drop_count}, 0);
        // R1: empty bitmap after reset drops a packet
        run_pkt("R1 empty table", 64'h4701_0010_0000_0000, 3, 1'b0, 1'b0, 8'd0, 32'd0);

        tbl_write(8'd8,   32'h0000_0001); // PID 256
        tbl_write(8'd255, 32'h8000_0000); // PID 8191
        tbl_write(8'd0,   32'h0000_0004); // PID 2
        tbl_write(8'd1,   32'h0000_0008); // PID 35

        for (int v = 0; v < 10; v++) begin
            cfg_filter_en = VEC[v][75];
            cfg_pid_lsb   = VEC[v][74:69];
            cfg_pid_width = VEC[v][68:65];
            run_pkt(VTAG[v], VEC[v][64:1], v + 11, VEC[v][0], 1'b0, 8'd0, 32'd0);
        end
        cfg_filter_en = 1'b1; cfg_pid_lsb = 6'd40; cfg_pid_width = 4'd13;

        chk("R9 pass_count", pass_count == 16'(exp_pass), pass_count, exp_pass);
        chk("R9 drop_count", drop_count == 16'(exp_drop), drop_count, exp_drop);

        // R2: width above 13 acts as 13
        cfg_pid_width = 4'd15;
        run_pkt("R2 width clamp", 64'h47E1_0010_0000_0000, 5, 1'b1, 1'b0, 8'd0, 32'd0);
        cfg_pid_width = 4'd13;

        // R7: stray bytes before a start marker
        @(negedge clk);
        for (int j = 0; j < 3; j++) begin
            in_valid = 1'b1; in_sop = 1'b0; in_data = 8'h47;
            @(negedge clk);
        end
        in_valid = 1'b0;
        run_pkt("R7 stray bytes", 64'h4701_0010_0000_0000, 9, 1'b1, 1'b0, 8'd0, 32'd0);

        // R8: bitmap writes during a packet body apply to the next packet
        run_pkt("R8 late set", 64'h4701_0110_0000_0000, 21, 1'b0, 1'b1, 8'd8, 32'h0000_0003);
        run_pkt("R8 next set", 64'h4701_0110_0000_0000, 22, 1'b1, 1'b0, 8'd0, 32'd0);
        run_pkt("R8 late clr", 64'h4701_0010_0000_0000, 23, 1'b1, 1'b1, 8'd8, 32'h0000_0000);
        run_pkt("R8 next clr", 64'h4701_0010_0000_0000, 24, 1'b0, 1'b0, 8'd0, 32'd0);
        tbl_write(8'd8, 32'h0000_0001);

        // R10: output stalls
        bp_mode = 1'b1;
        run_pkt("R10 backpressure", 64'h47FF_FF10_0000_0000, 31, 1'b1, 1'b0, 8'd0, 32'd0);
        bp_mode = 1'b0;
        repeat (2) @(negedge clk);

        // R6: whole-table clear
        @(negedge clk); tbl_clear = 1'b1;
        @(negedge clk); tbl_clear = 1'b0;
        run_pkt("R6 after clear 8191", 64'h47FF_FF10_0000_0000, 41, 1'b0, 1'b0, 8'd0, 32'd0);
        run_pkt("R6 after clear 256",  64'h4701_0010_0000_0000, 42, 1'b0, 1'b0, 8'd0, 32'd0);

        #1;
        chk("R9 final pass", pass_count == 16'(exp_pass), pass_count, exp_pass);
        chk("R9 final drop", drop_count == 16'(exp_drop), drop_count, exp_drop);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule